// File: doc/BRIEF.md
# Queue-Head Packet Age Timeout

This block guards the head of a packet queue against stale traffic. It keeps a small FIFO of tags. Each tag holds the packet's 2-bit type and the value of a coarse seconds counter at the moment the packet was accepted. The counter advances by one on every pulse of a time-tick input. The age of an entry is worked out only when that entry becomes the head of the queue. Age is the current counter value minus the stored stamp, taken modulo the counter width, so the result stays correct when the counter wraps.

A head entry whose age is at most the limit (64 by default) is offered on the dequeue port. A head entry that is older than the limit is removed internally: dequeue valid stays low for it, and the next entry is judged in the following cycle. Each such removal sets the status bit for the discarded packet's type. Software clears a status bit by writing a one to it.

The payload itself is held outside this block. The block only decides, tag by tag, whether a packet is forwarded or dropped.

Top module: `aq_head_timeout`

## Requirements
- R1: After reset the queue is empty, `deq_valid_o` is 0, `enq_ready_o` is 1, `sts_o` is 0 and the seconds counter is 0.
- R2: Accepted entries leave in arrival order. `deq_kind_o` shows the head entry's type while `deq_valid_o` is 1. An entry leaves on a cycle with `deq_valid_o` and `deq_ready_i` both high; otherwise the head and its type stay put.
- R3: The seconds counter increments on each cycle with `tick_i` high. An entry is stamped with the counter value present in its enqueue cycle, before that cycle's increment.
- R4: A head entry whose age is 64 or less is offered with `deq_valid_o` high. A head entry whose age is greater than 64 is dropped in that cycle with `deq_valid_o` low.
- R5: The age rule applies to every type code: 0 posted, 1 non-posted, 2 completion, 3 internally inserted.
- R6: A drop sets `sts_o[k]`, where k is the dropped entry's type code. Drops of other types leave that bit alone.
- R7: A dropped head is popped without a dequeue handshake. The next entry is judged in the following cycle, so a run of expired entries drains at one entry per cycle.
- R8: A cycle with `sts_wr_i` high clears each status bit whose `sts_wdata_i` bit is 1. Bits written with 0 keep their value.
- R9: If a drop of type k and a clear of bit k fall in the same cycle, `sts_o[k]` is 1 afterwards.
- R10: Age is computed modulo 2^TS_W, so an entry stamped just before the counter wraps is judged by its true age.
- R11: `enq_ready_o` is 0 while DEPTH entries are held. An enqueue attempt in that state adds no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second time pulse |
| enq_valid_i | input | 1 | Enqueue request |
| enq_ready_o | output | 1 | Queue can accept an entry |
| enq_kind_i | input | 2 | Packet type of the entry being enqueued |
| deq_valid_o | output | 1 | Head entry is young enough to forward |
| deq_ready_i | input | 1 | Consumer takes the head entry |
| deq_kind_o | output | 2 | Packet type of the head entry |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 4 | Write-one-to-clear mask for the status bits |
| sts_o | output | 4 | Per-type discard status |

## Verification
Two pairs of events can fall in the same cycle. A head drop can meet a status clear of the same bit. The bench provokes this by holding an all-ones clear write across the whole aging window of a completion entry, so the drop cycle lands under the write; the bit must read 1 in the cycle after the drop. An enqueue can also land in the same cycle as an internal drop or a handshake pop. A long random phase mixes ticks, stalls, enqueues and clears, and a behavioural queue model judges every output on every clock.

// File: rtl/aq_pkg.sv
package aq_pkg;

   localparam int unsigned KIND_W    = 2;
   localparam int unsigned NUM_KINDS = 1 << KIND_W;

   typedef enum logic [KIND_W-1:0] {
      KIND_POSTED    = 2'd0,
      KIND_NONPOSTED = 2'd1,
      KIND_CPL       = 2'd2,
      KIND_INSERTED  = 2'd3
   } pkt_kind_e;

endpackage

// File: rtl/aq_sec_timer.sv
module aq_sec_timer #(
   parameter int unsigned TS_W = 8
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            tick_i,
   output logic [TS_W-1:0] now_o
);

   logic [TS_W-1:0] count_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         count_q <= '0;
      else if (tick_i)
         count_q <= count_q + 1'b1;
   end

   assign now_o = count_q;

   // R3
   tick_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i |=> (now_o == $past(now_o) + 1'b1));

   // R3
   no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(now_o));

endmodule

// File: rtl/aq_tag_fifo.sv
module aq_tag_fifo #(
   parameter int unsigned ENT_W = 10,
   parameter int unsigned DEPTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             push_i,
   input  logic [ENT_W-1:0] push_data_i,
   input  logic             pop_i,
   output logic [ENT_W-1:0] head_o,
   output logic             empty_o,
   output logic             full_o
);

   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = PTR_W + 1;

   logic [ENT_W-1:0] slot_q [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
   logic [CNT_W-1:0] count_q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk_i) begin
         if (!rst_ni)
            slot_q[i] <= '0;
         else if (push_i && (wr_ptr_q == PTR_W'(i)))
            slot_q[i] <= push_data_i;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
         case ({push_i, pop_i})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   assign head_o  = slot_q[rd_ptr_q];
   assign empty_o = (count_q == '0);
   assign full_o  = (count_q == CNT_W'(DEPTH));

   // R11
   no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_i |-> !full_o);

   // R7
   no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_i |-> !empty_o);

endmodule

// File: rtl/aq_age_judge.sv
module aq_age_judge
   import aq_pkg::*;
#(
   parameter int unsigned TS_W  = 8,
   parameter int unsigned LIMIT = 64
) (
   input  logic              head_present_i,
   input  logic [KIND_W-1:0] head_kind_i,
   input  logic [TS_W-1:0]   head_stamp_i,
   input  logic [TS_W-1:0]   now_i,
   output logic              drop_o,
   output logic [NUM_KINDS-1:0] drop_vec_o
);

   localparam logic [TS_W-1:0] LIMIT_V = TS_W'(LIMIT);

   logic [TS_W-1:0] age;

   always_comb begin
      age    = now_i - head_stamp_i;
      drop_o = head_present_i && (age > LIMIT_V);
   end

   for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
      assign drop_vec_o[k] = drop_o && (head_kind_i == KIND_W'(k));
   end

   // R6
   one_kind_chk: assert final ($onehot0(drop_vec_o));

endmodule

// File: rtl/aq_status_reg.sv
module aq_status_reg #(
   parameter int unsigned NBITS = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [NBITS-1:0] set_i,
   input  logic             wr_i,
   input  logic [NBITS-1:0] wdata_i,
   output logic [NBITS-1:0] sts_o
);

   logic [NBITS-1:0] sts_q;

   for (genvar b = 0; b < NBITS; b++) begin : g_bit
      always_ff @(posedge clk_i) begin
         if (!rst_ni)
            sts_q[b] <= 1'b0;
         else if (set_i[b])
            sts_q[b] <= 1'b1;
         else if (wr_i && wdata_i[b])
            sts_q[b] <= 1'b0;
      end

      // R9
      set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         set_i[b] |=> sts_o[b]);

      // R8
      w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!set_i[b] && wr_i && wdata_i[b]) |=> !sts_o[b]);

      // R8
      zero_write_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!set_i[b] && !(wr_i && wdata_i[b])) |=> (sts_o[b] == $past(sts_o[b])));
   end

   assign sts_o = sts_q;

endmodule

// File: rtl/aq_head_timeout.sv
module aq_head_timeout
   import aq_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned TS_W  = 8,
   parameter int unsigned LIMIT = 64
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       tick_i,
   input  logic       enq_valid_i,
   output logic       enq_ready_o,
   input  logic [1:0] enq_kind_i,
   output logic       deq_valid_o,
   input  logic       deq_ready_i,
   output logic [1:0] deq_kind_o,
   input  logic       sts_wr_i,
   input  logic [3:0] sts_wdata_i,
   output logic [3:0] sts_o
);

   localparam int unsigned ENT_W = KIND_W + TS_W;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("aq_head_timeout: DEPTH must be a power of two >= 2");
   end
   if (TS_W > 30 || (1 << TS_W) <= 2 * LIMIT) begin : g_bad_ts
      $error("aq_head_timeout: TS_W too narrow for LIMIT");
   end

   logic [TS_W-1:0]      now;
   logic [ENT_W-1:0]     head;
   logic                 empty, full;
   logic                 push, pop, drop;
   logic [NUM_KINDS-1:0] drop_vec;
   logic [KIND_W-1:0]    head_kind;
   logic [TS_W-1:0]      head_stamp;

   aq_sec_timer #(.TS_W(TS_W)) timer_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .now_o  (now)
   );

   assign enq_ready_o = !full;
   assign push        = enq_valid_i && enq_ready_o;
   assign pop         = drop || (deq_valid_o && deq_ready_i);

   aq_tag_fifo #(.ENT_W(ENT_W), .DEPTH(DEPTH)) fifo_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (push),
      .push_data_i ({enq_kind_i, now}),
      .pop_i       (pop),
      .head_o      (head),
      .empty_o     (empty),
      .full_o      (full)
   );

   assign head_kind  = head[ENT_W-1 -: KIND_W];
   assign head_stamp = head[TS_W-1:0];

   aq_age_judge #(.TS_W(TS_W), .LIMIT(LIMIT)) judge_i (
      .head_present_i (!empty),
      .head_kind_i    (head_kind),
      .head_stamp_i   (head_stamp),
      .now_i          (now),
      .drop_o         (drop),
      .drop_vec_o     (drop_vec)
   );

   assign deq_valid_o = !empty && !drop;
   assign deq_kind_o  = head_kind;

   aq_status_reg #(.NBITS(NUM_KINDS)) status_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (drop_vec),
      .wr_i    (sts_wr_i),
      .wdata_i (sts_wdata_i),
      .sts_o   (sts_o)
   );

   // R4
   drop_hides_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drop |-> !deq_valid_o);

   // R2
   stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (deq_valid_o && !deq_ready_i) |=> ((deq_valid_o && $stable(deq_kind_o)) || drop));

   // R11
   full_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      full |-> !enq_ready_o);

endmodule

// File: tb/aq_head_timeout_tb.sv
module aq_head_timeout_tb_top;

   localparam int DEPTH = 8;
   localparam int TS_W  = 8;
   localparam int LIMIT = 64;
   localparam int MASK  = (1 << TS_W) - 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, ev = 1'b0, dr = 1'b0, wr = 1'b0;
   logic [1:0] ek = 2'd0;
   logic [3:0] wd = 4'd0;
   logic       enq_ready, deq_valid;
   logic [1:0] deq_kind;
   logic [3:0] sts;

   always #2.5 clk = ~clk;

   aq_head_timeout #(.DEPTH(DEPTH), .TS_W(TS_W), .LIMIT(LIMIT)) dut_i (
      .clk_i (clk), .rst_ni (rst_n), .tick_i (tick),
      .enq_valid_i (ev), .enq_ready_o (enq_ready), .enq_kind_i (ek),
      .deq_valid_o (deq_valid), .deq_ready_i (dr), .deq_kind_o (deq_kind),
      .sts_wr_i (wr), .sts_wdata_i (wd), .sts_o (sts));

   int errors = 0, checks = 0;
   int sec = 0;
   int m_sts = 0;
   int q_kind[$];
   int q_stamp[$];
   bit finished = 0;

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic step(input string tag);
      bit hv, ex, full_b;
      int age, set;
      #1;
      hv = q_kind.size() > 0;
      ex = 0;
      if (hv) begin
         age = (sec - q_stamp[0]) & MASK;
         ex  = age > LIMIT;
      end
      full_b = q_kind.size() >= DEPTH;
      check(tag, "deq_valid", deq_valid, hv && !ex);
      if (hv && !ex) check(tag, "deq_kind", deq_kind, q_kind[0]);
      check(tag, "enq_ready", enq_ready, !full_b);
      check(tag, "status", sts, m_sts);
      @(posedge clk);
      set = 0;
      if (hv && ex) begin
         set = 1 << q_kind[0];
         void'(q_kind.pop_front());
         void'(q_stamp.pop_front());
      end else if (hv && dr) begin
         void'(q_kind.pop_front());
         void'(q_stamp.pop_front());
      end
      if (ev && !full_b) begin
         q_kind.push_back(ek);
         q_stamp.push_back(sec);
      end
      if (wr) m_sts = m_sts & ~wd;
      m_sts = m_sts | set;
      if (tick) sec = (sec + 1) & MASK;
      @(negedge clk);
   endtask

   task automatic idle(input string tag, input int n, input bit tk, input bit rdy);
      ev = 0; tick = tk; dr = rdy;
      for (int i = 0; i < n; i++) step(tag);
      tick = 0; dr = 0;
   endtask

   task automatic push1(input string tag, input int kind, input bit tk);
      ev = 1; ek = 2'(kind); tick = tk;
      step(tag);
      ev = 0; tick = 0;
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      // R1 reset state
      idle("R1", 2, 0, 0);
      // R2 / R5 ordering and type codes
      for (int k = 0; k < 4; k++) push1("R5", k, 0);
      idle("R2", 3, 0, 0);
      idle("R2", 5, 0, 1);
      // R3 / R4 boundary: age 64 kept, 65 dropped
      push1("R3", 1, 1);
      idle("R4", 63, 1, 0);
      idle("R4", 3, 1, 0);
      // R5 / R6 / R7 all types aged, drained one per cycle
      for (int k = 3; k >= 0; k--) push1("R6", k, 0);
      idle("R6", 66, 1, 0);
      idle("R7", 6, 0, 0);
      // R8 partial clear
      wr = 1; wd = 4'b0101; step("R8"); wr = 0; wd = 0;
      step("R8");
      wr = 1; wd = 4'b1010; step("R8"); wr = 0; wd = 0;
      step("R8");
      // R9 drop under an all-ones clear
      push1("R9", 2, 0);
      wr = 1; wd = 4'hF;
      idle("R9", 67, 1, 0);
      wr = 0; wd = 0;
      idle("R9", 2, 0, 0);
      // R10 wrap: stamp near the top of the counter
      while (sec != MASK - 5) idle("R10", 1, 1, 0);
      push1("R10", 0, 1);
      idle("R10", 20, 1, 0);
      idle("R10", 3, 0, 1);
      // R11 full queue
      ev = 1; dr = 0;
      for (int i = 0; i < DEPTH + 3; i++) begin ek = 2'(i); step("R11"); end
      ev = 0;
      idle("R11", DEPTH + 2, 0, 1);
      // R2 random mix
      for (int i = 0; i < 4000; i++) begin
         ev   = ($urandom % 3) != 0;
         ek   = 2'($urandom);
         dr   = ($urandom % 4) == 0;
         tick = ($urandom % 2) == 0;
         wr   = ($urandom % 16) == 0;
         wd   = 4'($urandom);
         step("R2");
      end
      ev = 0; wr = 0; tick = 0;
      idle("R2", 12, 0, 1);
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule